// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides whether one regulator channel may report its output as good. It runs from a slow clock of roughly 256 kHz and looks at two window comparator results: a tight window (feedback within ±5% of its target) and a wide window (feedback within ±10%). It also takes a soft-start-complete flag and a combined fault-or-disable input. Its single output is an active-high good flag, which a pad outside this block drives as an open-drain pin.

Qualification is deliberately asymmetric. Turning good on is slow: the feedback must stay inside the tight window without a break for a full qualification period (256 clocks by default, about 1 ms). Turning good off is fast: it happens at the next clock edge after the feedback leaves the wide window, or after a fault or disable appears. Between the two windows an asserted flag is held, so ripple near the tight limit does not make the output chatter. After any drop, a fresh full qualification is needed.

Top module: `pgmon_window`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it is released, pg_o is 0.
- R2: With ss_done_i = 1, force_off_i = 0 and win_wide_i = 1, pg_o becomes 1 at the edge that samples win_tight_i = 1 for the QUAL_CYCLES-th consecutive time (256 by default); after QUAL_CYCLES-1 such edges it is still 0.
- R3: Any edge that samples win_tight_i = 0 while pg_o is 0 resets qualification to zero, so a full QUAL_CYCLES further consecutive edges with win_tight_i = 1 are needed.
- R4: When pg_o is 1 and an edge samples win_wide_i = 0, pg_o is 0 after that edge. win_wide_i = 0 outranks win_tight_i = 1.
- R5: When pg_o is 1, win_wide_i = 1 and win_tight_i = 0, with no fault and soft start done, pg_o stays 1.
- R6: An edge that samples force_off_i = 1 makes pg_o 0 after that edge; while force_off_i stays 1 pg_o stays 0 and no qualification builds up.
- R7: While ss_done_i = 0, pg_o stays 0 and no qualification builds up, whatever the window inputs.
- R8: After pg_o drops for any reason, it rises again only after a fresh run of QUAL_CYCLES consecutive qualifying edges.
- R9: The qualification count saturates: pg_o stays 1 for any length of time inside the tight window, with no wrap-around glitch.
- R10: If force_off_i = 1 is sampled at the same edge that would complete qualification, pg_o stays 0 and the next qualification starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock, about 256 kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| win_tight_i | input | 1 | 1 when feedback is within ±5% of target |
| win_wide_i | input | 1 | 1 when feedback is within ±10% of target |
| ss_done_i | input | 1 | 1 once soft start has finished |
| force_off_i | input | 1 | 1 during any fault or while the channel is disabled |
| pg_o | output | 1 | Active-high power-good flag |

## Verification
The two functions that can land on the same edge are completion of the qualification run and the forced-off path. The bench builds a run of QUAL_CYCLES-1 qualifying edges and then raises force_off_i so that it is sampled on exactly the edge that would finish the run. The result is judged correct only if pg_o stays 0 at that edge, and if a later release needs a full fresh run: 0 after QUAL_CYCLES-1 edges and 1 after QUAL_CYCLES.

// File: rtl/pgmon_pkg.sv
// Package for the power-good window monitor.
// Holds the controller state encoding shared by the controller and the top.
package pgmon_pkg;

    typedef enum logic [1:0] {
        PG_OFF  = 2'd0,   // forced low: fault, disable or soft start running
        PG_QUAL = 2'd1,   // not good, building a qualification run
        PG_GOOD = 2'd2    // good flag asserted
    } pg_state_t;

endpackage

// File: rtl/pgmon_gate.sv
// Input conditioning for the power-good monitor.
// Folds the window and control inputs into the three conditions the
// controller and the counter need. Assumes the inputs are already
// synchronous to clk. A tight-window flag without the wide-window flag is
// inconsistent and is treated as outside both windows.
module pgmon_gate (
    input  logic win_tight_i,
    input  logic win_wide_i,
    input  logic ss_done_i,
    input  logic force_off_i,
    output logic inhibit_o,
    output logic outside_wide_o,
    output logic qual_clr_o
);

    logic tight_ok;

    // Derive inhibit, wide-window exit and qualification clear
    always_comb begin
        inhibit_o      = force_off_i | ~ss_done_i;
        tight_ok       = win_tight_i & win_wide_i;
        outside_wide_o = ~win_wide_i;
        qual_clr_o     = inhibit_o | ~tight_ok;
    end

endmodule

// File: rtl/pgmon_qual_cnt.sv
// Saturating qualification counter.
// Counts consecutive clock edges at which clr_i is low and stops at LIMIT.
// ripe_o tells the controller that the current edge, if not cleared, is
// the LIMIT-th consecutive one. Assumes LIMIT >= 2.
module pgmon_qual_cnt #(
    parameter int unsigned LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic ripe_o
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_RIPE = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear, hold at the ceiling, or advance by one
    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Flag that this edge completes the run
    always_comb begin
        ripe_o = ~clr_i & (cnt_q >= CNT_RIPE);
    end

endmodule

// File: rtl/pgmon_fsm.sv
// Power-good controller.
// Three states: forced off, qualifying and good. Inhibit wins over
// everything, a wide-window exit drops good at once, and qualification
// completion raises good. The good flag comes straight from the state
// register, so it has no combinational path from the inputs.
module pgmon_fsm
    import pgmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit_i,
    input  logic outside_wide_i,
    input  logic ripe_i,
    output logic pg_o
);

    pg_state_t state_q;
    pg_state_t state_d;

    // Next-state decision with inhibit first, then drop, then rise
    always_comb begin
        state_d = state_q;
        if (inhibit_i) begin
            state_d = PG_OFF;
        end else begin
            case (state_q)
                PG_GOOD: begin
                    if (outside_wide_i) begin
                        state_d = PG_QUAL;
                    end
                end
                PG_OFF, PG_QUAL: begin
                    state_d = ripe_i ? PG_GOOD : PG_QUAL;
                end
                default: state_d = PG_OFF;
            endcase
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Good flag decoded from the registered state
    always_comb begin
        pg_o = (state_q == PG_GOOD);
    end

endmodule

// File: rtl/pgmon_window.sv
// Power-good window monitor, top level.
// Raises pg_o after QUAL_CYCLES consecutive clocks inside the tight window,
// holds it while the feedback stays inside the wide window, and drops it
// one edge after a wide-window exit, a fault, a disable or a return to
// soft start. Assumes all inputs are synchronous to clk.
module pgmon_window #(
    parameter int unsigned QUAL_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_tight_i,
    input  logic win_wide_i,
    input  logic ss_done_i,
    input  logic force_off_i,
    output logic pg_o
);

    logic inhibit;
    logic outside_wide;
    logic qual_clr;
    logic ripe;

    pgmon_gate u_gate (
        .win_tight_i    (win_tight_i),
        .win_wide_i     (win_wide_i),
        .ss_done_i      (ss_done_i),
        .force_off_i    (force_off_i),
        .inhibit_o      (inhibit),
        .outside_wide_o (outside_wide),
        .qual_clr_o     (qual_clr)
    );

    pgmon_qual_cnt #(
        .LIMIT (QUAL_CYCLES)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (qual_clr),
        .ripe_o (ripe)
    );

    pgmon_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .inhibit_i      (inhibit),
        .outside_wide_i (outside_wide),
        .ripe_i         (ripe),
        .pg_o           (pg_o)
    );

endmodule

// File: rtl/pgmon_window_chk.sv
// Property checker for the power-good window monitor.
// Keeps its own run-length count of qualifying edges, built from the ports
// only, and relates it to the rising edge of the good flag.
module pgmon_window_chk #(
    parameter int unsigned QUAL_CYCLES = 256
) (
    input logic clk,
    input logic rst_n,
    input logic win_tight_i,
    input logic win_wide_i,
    input logic ss_done_i,
    input logic force_off_i,
    input logic pg_o
);

    localparam int unsigned RUN_W = $clog2(QUAL_CYCLES + 1);

    logic [RUN_W-1:0] run_q;
    logic             qualifying;

    // Port-level view of a qualifying edge
    always_comb begin
        qualifying = win_tight_i & win_wide_i & ss_done_i & ~force_off_i;
    end

    // Independent run-length count, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !qualifying) begin
            run_q <= '0;
        end else if (run_q != RUN_W'(QUAL_CYCLES)) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |=> !pg_o);

    // R2
    rise_after_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> ($past(run_q) == RUN_W'(QUAL_CYCLES - 1)));

    // R3
    no_rise_outside_tight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_o && !win_tight_i) |=> !pg_o);

    // R4
    wide_exit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wide_i |=> !pg_o);

    // R5
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_o && win_wide_i && ss_done_i && !force_off_i) |=> pg_o);

    // R6
    force_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> !pg_o);

    // R7
    soft_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done_i |=> !pg_o);

endmodule

bind pgmon_window pgmon_window_chk #(
    .QUAL_CYCLES (QUAL_CYCLES)
) u_pgmon_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_tight_i (win_tight_i),
    .win_wide_i  (win_wide_i),
    .ss_done_i   (ss_done_i),
    .force_off_i (force_off_i),
    .pg_o        (pg_o)
);

// File: tb/pgmon_window_test.sv
// Directed bench for the power-good window monitor.
// Inputs change and outputs are sampled at the falling clock edge.
module pgmon_window_test;

    localparam int unsigned QUAL = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_tight = 1'b0;
    logic win_wide = 1'b0;
    logic ss_done = 1'b0;
    logic force_off = 1'b0;
    logic pg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgmon_window #(.QUAL_CYCLES(QUAL)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_tight_i (win_tight),
        .win_wide_i  (win_wide),
        .ss_done_i   (ss_done),
        .force_off_i (force_off),
        .pg_o        (pg)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (pg !== exp) begin
            errors++;
            $display("FAIL %s: pg_o actual %b expected %b at %0t", req, pg, exp, $time);
        end
    endtask

    task automatic set_in(input logic t, input logic w, input logic s, input logic f);
        win_tight = t;
        win_wide  = w;
        ss_done   = s;
        force_off = f;
    endtask

    // Qualify from zero: low after QUAL-1 edges, high after QUAL
    task automatic full_qualify(input string req);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(QUAL - 1);
        check(req, 1'b0);
        step(1);
        check(req, 1'b1);
    endtask

    task automatic t_reset;
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(300);
        check("R1 in reset", 1'b0);
        rst_n = 1'b1;
        step(1);
        check("R1 first edge", 1'b0);
        rst_n = 1'b0;
        step(2);
        set_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_startup;
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        step(400);
        check("R7 soft start running", 1'b0);
        full_qualify("R2 first qualification");
    endtask

    task automatic t_hold;
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        step(50);
        check("R5 held between windows", 1'b1);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(700);
        check("R9 long stay saturates", 1'b1);
    endtask

    task automatic t_wide_drop;
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        step(1);
        check("R4 wide exit drops", 1'b0);
        full_qualify("R8 fresh run after drop");
    endtask

    task automatic t_restart;
        set_in(1'b0, 1'b0, 1'b1, 1'b0);
        step(1);
        check("R4 drop before restart test", 1'b0);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(200);
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        step(1);
        check("R3 break in run", 1'b0);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(QUAL - 60);
        check("R3 old run discarded", 1'b0);
        step(59);
        check("R3 one short", 1'b0);
        step(1);
        check("R3 full new run", 1'b1);
    endtask

    task automatic t_fault;
        set_in(1'b1, 1'b1, 1'b1, 1'b1);
        step(1);
        check("R6 fault drops", 1'b0);
        step(400);
        check("R6 fault keeps low", 1'b0);
        full_qualify("R6 after fault release");
    endtask

    task automatic t_collide;
        set_in(1'b1, 1'b1, 1'b1, 1'b1);
        step(1);
        check("R10 setup drop", 1'b0);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        step(QUAL - 1);
        check("R10 one short", 1'b0);
        force_off = 1'b1;
        step(1);
        check("R10 fault on completing edge", 1'b0);
        full_qualify("R10 restart from zero");
    endtask

    initial begin
        t_reset();
        t_startup();
        t_hold();
        t_wide_drop();
        t_restart();
        t_fault();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule